// File: doc/BRIEF.md
# Calendar Clock Register Window with Write Unlock

This block sits between a processor bus and the counting logic of a calendar clock. The counter keeps seven byte-wide fields: seconds, minutes, hours, weekday, day, month and year. The processor never addresses these fields directly. Instead, a 2-bit pointer selects one pair of fields, and that pair appears in a high and a low value register. Each access to the high register moves the pointer down by one, so software can walk from year down to seconds with a run of accesses. The pointer stops at zero.

Alarm fields are reached the same way, through a second window with its own pointer. Both windows turn bus writes into per-field write strobes with a shared data byte for the counter, and they return the selected field values on reads.

Writes into the time fields are locked by a write-enable bit. That bit can only be set in the single cycle right after two fixed key bytes have been written back to back to a key register. Clearing the bit needs no key.

Top module: `cal_reg_window`

## Requirements
- R1: After reset both pointers are 0, write-enable is clear, and a read of the time low register (address 2) returns the seconds field.
- R2: The field bus packs field i in bits [8i+7:8i], with seconds=0, minutes=1, hours=2, weekday=3, day=4, month=5, year=6. The time window shows these pairs (high/low): pointer 0 gives minutes/seconds, 1 gives weekday/hours, 2 gives month/day, and 3 gives year in the low register with the high register reading 0.
- R3: Every valid read or write of a high register (address 1 for time, 4 for alarm) decrements its own pointer by one if it is nonzero, and leaves it at 0 otherwise. Low register accesses never move a pointer.
- R4: A write to the time control register (address 0) loads the time pointer from bits [1:0]. A read returns the pointer in [1:0] and write-enable in bit 4. The alarm control register (address 3) holds the alarm pointer in [1:0].
- R5: A control write with bit 4 set sets write-enable only when it comes in the cycle right after key register (address 6) writes of 0x55 and then 0xAA in consecutive cycles.
- R6: A cycle with no access, or any other key value, between 0x55 and 0xAA cancels the unlock, and a later control write with bit 4 set leaves write-enable clear.
- R7: A control write with bit 4 clear clears write-enable at once, with no key sequence.
- R8: While write-enable is clear, writes to the time value registers produce no field strobe, and a high-register write still decrements the pointer.
- R9: While write-enable is set, a write to a time value register raises the strobe of exactly the field that register shows, with the written byte on the data output, in the same cycle.
- R10: The alarm window uses the same field mapping, has a pointer independent of the time pointer, and its writes are not gated by write-enable.
- R11: A high-register write at pointer 3 produces no strobe, because the year sits only in the low register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | Bus access in this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | 3 | Register address |
| acc_wdata_i | input | 8 | Write data |
| acc_rdata_o | output | 8 | Read data, valid in the access cycle |
| tm_fields_i | input | 56 | Current time fields from the counter |
| tm_wr_o | output | 7 | Time field write strobes, one per field |
| al_fields_i | input | 56 | Current alarm fields |
| al_wr_o | output | 7 | Alarm field write strobes, one per field |
| fld_wdata_o | output | 8 | Byte to write into the strobed field |

## Verification
The hardest state to reach from the ports is the one-cycle unlock opening: the control write has to land exactly one cycle after the 0xAA key write, which in turn has to follow 0x55 with no gap. The bench drives back-to-back accesses with no idle cycle between them to hit that cycle. Then, using the same routine, it inserts a single idle cycle or a wrong key byte at each position to show the opening is missed. The write-enable state is observed only through control register reads and through the presence or absence of field strobes.

// File: rtl/cal_win_pkg.sv
package cal_win_pkg;
  localparam int unsigned FIELD_N = 7;
  localparam int unsigned FIDX_W  = 3;
  localparam int unsigned PTR_W   = 2;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned WEN_BIT = 4;

  localparam logic [FIDX_W-1:0] F_SEC  = 3'd0;
  localparam logic [FIDX_W-1:0] F_MIN  = 3'd1;
  localparam logic [FIDX_W-1:0] F_HOUR = 3'd2;
  localparam logic [FIDX_W-1:0] F_WDAY = 3'd3;
  localparam logic [FIDX_W-1:0] F_DAY  = 3'd4;
  localparam logic [FIDX_W-1:0] F_MON  = 3'd5;
  localparam logic [FIDX_W-1:0] F_YEAR = 3'd6;

  localparam logic [ADDR_W-1:0] A_TM_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_TM_HI   = 3'd1;
  localparam logic [ADDR_W-1:0] A_TM_LO   = 3'd2;
  localparam logic [ADDR_W-1:0] A_AL_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] A_AL_HI   = 3'd4;
  localparam logic [ADDR_W-1:0] A_AL_LO   = 3'd5;
  localparam logic [ADDR_W-1:0] A_KEY     = 3'd6;

  typedef enum logic [1:0] {
    UL_IDLE = 2'd0,
    UL_HALF = 2'd1,
    UL_OPEN = 2'd2
  } unlock_e;
endpackage

// File: rtl/cal_unlock.sv
module cal_unlock
  import cal_win_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter logic [DATA_W-1:0] KEY_A = 8'h55,
  parameter logic [DATA_W-1:0] KEY_B = 8'hAA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_wr_i,
  input  logic [DATA_W-1:0] key_data_i,
  output logic              open_o
);
  unlock_e state_q, state_d;

  // Every cycle falls back to idle unless the exact next key byte arrives.
  always_comb begin
    state_d = UL_IDLE;
    if (key_wr_i) begin
      if (key_data_i == KEY_A)
        state_d = UL_HALF;
      else if (state_q == UL_HALF && key_data_i == KEY_B)
        state_d = UL_OPEN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= UL_IDLE;
    else         state_q <= state_d;
  end

  assign open_o = (state_q == UL_OPEN);
endmodule

// File: rtl/cal_ptr_window.sv
module cal_ptr_window
  import cal_win_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned BUS_W = FIELD_N * DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ptr_ld_i,
  input  logic [PTR_W-1:0]   ptr_val_i,
  input  logic               hi_acc_i,
  input  logic               hi_wr_i,
  input  logic               lo_wr_i,
  input  logic               wr_allow_i,
  input  logic [BUS_W-1:0]   fields_i,
  output logic [PTR_W-1:0]   ptr_o,
  output logic [DATA_W-1:0]  hi_rdata_o,
  output logic [DATA_W-1:0]  lo_rdata_o,
  output logic [FIELD_N-1:0] fld_wr_o
);
  logic [PTR_W-1:0]  ptr_q;
  logic [FIDX_W-1:0] hi_idx, lo_idx;
  logic              hi_vld;

  always_comb begin
    hi_vld = 1'b1;
    unique case (ptr_q)
      2'd0: begin hi_idx = F_MIN;  lo_idx = F_SEC;  end
      2'd1: begin hi_idx = F_WDAY; lo_idx = F_HOUR; end
      2'd2: begin hi_idx = F_MON;  lo_idx = F_DAY;  end
      default: begin hi_idx = F_SEC; lo_idx = F_YEAR; hi_vld = 1'b0; end
    endcase
  end

  assign hi_rdata_o = hi_vld ? fields_i[hi_idx*DATA_W +: DATA_W] : '0;
  assign lo_rdata_o = fields_i[lo_idx*DATA_W +: DATA_W];

  for (genvar g = 0; g < FIELD_N; g++) begin : g_strb
    assign fld_wr_o[g] = wr_allow_i &
                         ((hi_wr_i & hi_vld & (hi_idx == FIDX_W'(g))) |
                          (lo_wr_i & (lo_idx == FIDX_W'(g))));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       ptr_q <= '0;
    else if (ptr_ld_i)                 ptr_q <= ptr_val_i;
    else if (hi_acc_i && ptr_q != '0)  ptr_q <= ptr_q - 1'b1;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/cal_reg_window.sv
module cal_reg_window
  import cal_win_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter logic [DATA_W-1:0] KEY_A = 8'h55,
  parameter logic [DATA_W-1:0] KEY_B = 8'hAA
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       acc_valid_i,
  input  logic                       acc_write_i,
  input  logic [ADDR_W-1:0]          acc_addr_i,
  input  logic [DATA_W-1:0]          acc_wdata_i,
  output logic [DATA_W-1:0]          acc_rdata_o,
  input  logic [FIELD_N*DATA_W-1:0]  tm_fields_i,
  output logic [FIELD_N-1:0]         tm_wr_o,
  input  logic [FIELD_N*DATA_W-1:0]  al_fields_i,
  output logic [FIELD_N-1:0]         al_wr_o,
  output logic [DATA_W-1:0]          fld_wdata_o
);
  logic sel_tm_ctrl, sel_tm_hi, sel_tm_lo;
  logic sel_al_ctrl, sel_al_hi, sel_al_lo, sel_key;
  logic wr;
  logic wr_en_q;
  logic unlock_open;
  logic [PTR_W-1:0]  tm_ptr, al_ptr;
  logic [DATA_W-1:0] tm_hi_rd, tm_lo_rd, al_hi_rd, al_lo_rd;

  assign wr          = acc_valid_i & acc_write_i;
  assign sel_tm_ctrl = acc_valid_i & (acc_addr_i == A_TM_CTRL);
  assign sel_tm_hi   = acc_valid_i & (acc_addr_i == A_TM_HI);
  assign sel_tm_lo   = acc_valid_i & (acc_addr_i == A_TM_LO);
  assign sel_al_ctrl = acc_valid_i & (acc_addr_i == A_AL_CTRL);
  assign sel_al_hi   = acc_valid_i & (acc_addr_i == A_AL_HI);
  assign sel_al_lo   = acc_valid_i & (acc_addr_i == A_AL_LO);
  assign sel_key     = acc_valid_i & (acc_addr_i == A_KEY);

  cal_unlock #(.DATA_W(DATA_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) i_unlock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_wr_i   (sel_key & acc_write_i),
    .key_data_i (acc_wdata_i),
    .open_o     (unlock_open)
  );

  // Clear always wins; set only in the open cycle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_en_q <= 1'b0;
    else if (sel_tm_ctrl && acc_write_i) begin
      if (!acc_wdata_i[WEN_BIT])  wr_en_q <= 1'b0;
      else if (unlock_open)       wr_en_q <= 1'b1;
    end
  end

  cal_ptr_window #(.DATA_W(DATA_W)) i_tm_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ptr_ld_i   (sel_tm_ctrl & acc_write_i),
    .ptr_val_i  (acc_wdata_i[PTR_W-1:0]),
    .hi_acc_i   (sel_tm_hi),
    .hi_wr_i    (sel_tm_hi & wr),
    .lo_wr_i    (sel_tm_lo & wr),
    .wr_allow_i (wr_en_q),
    .fields_i   (tm_fields_i),
    .ptr_o      (tm_ptr),
    .hi_rdata_o (tm_hi_rd),
    .lo_rdata_o (tm_lo_rd),
    .fld_wr_o   (tm_wr_o)
  );

  cal_ptr_window #(.DATA_W(DATA_W)) i_al_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ptr_ld_i   (sel_al_ctrl & acc_write_i),
    .ptr_val_i  (acc_wdata_i[PTR_W-1:0]),
    .hi_acc_i   (sel_al_hi),
    .hi_wr_i    (sel_al_hi & wr),
    .lo_wr_i    (sel_al_lo & wr),
    .wr_allow_i (1'b1),
    .fields_i   (al_fields_i),
    .ptr_o      (al_ptr),
    .hi_rdata_o (al_hi_rd),
    .lo_rdata_o (al_lo_rd),
    .fld_wr_o   (al_wr_o)
  );

  assign fld_wdata_o = acc_wdata_i;

  always_comb begin
    acc_rdata_o = '0;
    unique case (acc_addr_i)
      A_TM_CTRL: begin
        acc_rdata_o[PTR_W-1:0] = tm_ptr;
        acc_rdata_o[WEN_BIT]   = wr_en_q;
      end
      A_TM_HI:   acc_rdata_o = tm_hi_rd;
      A_TM_LO:   acc_rdata_o = tm_lo_rd;
      A_AL_CTRL: acc_rdata_o[PTR_W-1:0] = al_ptr;
      A_AL_HI:   acc_rdata_o = al_hi_rd;
      A_AL_LO:   acc_rdata_o = al_lo_rd;
      default:   acc_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cal_reg_window_chk.sv
module cal_reg_window_chk
  import cal_win_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               acc_valid_i,
  input logic               acc_write_i,
  input logic [ADDR_W-1:0]  acc_addr_i,
  input logic [DATA_W-1:0]  acc_wdata_i,
  input logic [FIELD_N-1:0] tm_wr_o,
  input logic [FIELD_N-1:0] al_wr_o,
  input logic               wr_en_q,
  input logic               unlock_open,
  input logic [PTR_W-1:0]   tm_ptr,
  input logic [PTR_W-1:0]   al_ptr
);
  p_tm_ptr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_addr_i == A_TM_HI && tm_ptr != '0 |=> tm_ptr == $past(tm_ptr) - 1'b1);

  p_tm_ptr_floor_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_addr_i == A_TM_HI && tm_ptr == '0 |=> tm_ptr == '0);

  p_al_ptr_step_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_addr_i == A_AL_HI && al_ptr != '0 |=> al_ptr == $past(al_ptr) - 1'b1);

  p_tm_ptr_alone_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && (acc_addr_i == A_AL_HI || acc_addr_i == A_AL_CTRL) |=> $stable(tm_ptr));

  p_wen_key_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_en_q) |-> $past(unlock_open));

  p_wen_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_write_i && acc_addr_i == A_TM_CTRL && !acc_wdata_i[WEN_BIT] |=> !wr_en_q);

  p_locked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_q |-> tm_wr_o == '0);

  p_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tm_wr_o) && $onehot0(al_wr_o));

  p_strobe_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tm_wr_o != '0 || al_wr_o != '0) |-> acc_valid_i && acc_write_i);
endmodule

bind cal_reg_window cal_reg_window_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .acc_write_i (acc_write_i),
  .acc_addr_i  (acc_addr_i),
  .acc_wdata_i (acc_wdata_i),
  .tm_wr_o     (tm_wr_o),
  .al_wr_o     (al_wr_o),
  .wr_en_q     (wr_en_q),
  .unlock_open (unlock_open),
  .tm_ptr      (tm_ptr),
  .al_ptr      (al_ptr)
);

// File: tb/test_cal_reg_window.sv
module test_cal_reg_window;
  localparam int DW = 8;
  localparam int FN = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0;
  logic          write = 1'b0;
  logic [2:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [FN*DW-1:0] tm_f, al_f;
  logic [FN-1:0] tm_wr, al_wr;
  logic [DW-1:0] f_wdata;

  int total = 0;
  int bad = 0;
  logic [FN-1:0] cap_tm, cap_al;
  logic [DW-1:0] cap_wd;

  always #2.5 clk = ~clk;

  for (genvar i = 0; i < FN; i++) begin : g_f
    assign tm_f[i*DW +: DW] = 8'h30 + 8'(i);
    assign al_f[i*DW +: DW] = 8'hC0 + 8'(i);
  end

  cal_reg_window i_cal_reg_window (
    .clk_i(clk), .rst_ni(rst_n),
    .acc_valid_i(valid), .acc_write_i(write), .acc_addr_i(addr),
    .acc_wdata_i(wdata), .acc_rdata_o(rdata),
    .tm_fields_i(tm_f), .tm_wr_o(tm_wr),
    .al_fields_i(al_f), .al_wr_o(al_wr),
    .fld_wdata_o(f_wdata)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    valid = 1'b1; write = 1'b1; addr = a; wdata = d;
    #1;
    cap_tm = tm_wr; cap_al = al_wr; cap_wd = f_wdata;
    @(posedge clk);
    #0.5 valid = 1'b0; write = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    valid = 1'b1; write = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk);
    #0.5 valid = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    valid = 1'b0;
    @(posedge clk);
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    bus_rd(3'd0, d); check(d == 8'h00, "R1 ctrl after reset", d, 8'h00);
    bus_rd(3'd3, d); check(d == 8'h00, "R1 alarm ctrl after reset", d, 8'h00);
    bus_rd(3'd2, d); check(d == 8'h30, "R1 low reads seconds", d, 8'h30);
  endtask

  task automatic t_map_walk();
    logic [DW-1:0] d;
    bus_wr(3'd0, 8'h03);
    bus_rd(3'd2, d); check(d == 8'h36, "R2 ptr3 low is year", d, 8'h36);
    bus_rd(3'd0, d); check(d == 8'h03, "R3 low read keeps ptr", d, 8'h03);
    bus_rd(3'd1, d); check(d == 8'h00, "R2 ptr3 high reads zero", d, 8'h00);
    bus_rd(3'd0, d); check(d == 8'h02, "R3 high read steps ptr", d, 8'h02);
    bus_rd(3'd2, d); check(d == 8'h34, "R2 ptr2 low is day", d, 8'h34);
    bus_rd(3'd1, d); check(d == 8'h35, "R2 ptr2 high is month", d, 8'h35);
    bus_rd(3'd2, d); check(d == 8'h32, "R2 ptr1 low is hours", d, 8'h32);
    bus_rd(3'd1, d); check(d == 8'h33, "R2 ptr1 high is weekday", d, 8'h33);
    bus_rd(3'd1, d); check(d == 8'h31, "R2 ptr0 high is minutes", d, 8'h31);
    bus_rd(3'd1, d); check(d == 8'h31, "R3 ptr saturates at zero", d, 8'h31);
    bus_rd(3'd0, d); check(d == 8'h00, "R4 ctrl readback at zero", d, 8'h00);
  endtask

  task automatic t_locked();
    logic [DW-1:0] d;
    bus_wr(3'd0, 8'h02);
    bus_wr(3'd1, 8'h99); check(cap_tm == '0, "R8 locked high write no strobe", cap_tm, 0);
    bus_rd(3'd0, d); check(d == 8'h01, "R8 locked write still steps ptr", d, 8'h01);
    bus_wr(3'd2, 8'h98); check(cap_tm == '0, "R8 locked low write no strobe", cap_tm, 0);
    bus_wr(3'd0, 8'h10);
    bus_rd(3'd0, d); check(d == 8'h00, "R5 set without key refused", d, 8'h00);
  endtask

  task automatic t_unlock_ok();
    logic [DW-1:0] d;
    bus_wr(3'd6, 8'h55); bus_wr(3'd6, 8'hAA); bus_wr(3'd0, 8'h12);
    bus_rd(3'd0, d); check(d == 8'h12, "R5 unlock sets wen", d, 8'h12);
    bus_wr(3'd1, 8'h77);
    check(cap_tm == 7'h20, "R9 high write strobes month", cap_tm, 7'h20);
    check(cap_wd == 8'h77, "R9 strobe data", cap_wd, 8'h77);
    check(cap_al == '0, "R10 time write leaves alarm", cap_al, 0);
    bus_wr(3'd2, 8'h44); check(cap_tm == 7'h04, "R9 low write strobes hours", cap_tm, 7'h04);
    bus_wr(3'd0, 8'h03);
    bus_rd(3'd0, d); check(d == 8'h03, "R7 clear without key", d, 8'h03);
    bus_wr(3'd2, 8'h45); check(cap_tm == '0, "R7 cleared wen blocks write", cap_tm, 0);
    bus_wr(3'd6, 8'h55); bus_wr(3'd6, 8'hAA); bus_wr(3'd0, 8'h13);
    bus_wr(3'd1, 8'h21); check(cap_tm == '0, "R11 ptr3 high write no strobe", cap_tm, 0);
    bus_rd(3'd0, d); check(d == 8'h12, "R11 ptr3 high write steps ptr", d, 8'h12);
    bus_wr(3'd0, 8'h03);
    bus_wr(3'd6, 8'h55); bus_wr(3'd6, 8'hAA); bus_wr(3'd0, 8'h13);
    bus_wr(3'd2, 8'h22); check(cap_tm == 7'h40, "R9 ptr3 low strobes year", cap_tm, 7'h40);
    bus_wr(3'd0, 8'h00);
  endtask

  task automatic t_unlock_bad();
    logic [DW-1:0] d;
    bus_wr(3'd6, 8'h55); idle(); bus_wr(3'd6, 8'hAA); bus_wr(3'd0, 8'h10);
    bus_rd(3'd0, d); check(d == 8'h00, "R6 idle between keys", d, 8'h00);
    bus_wr(3'd6, 8'h55); bus_wr(3'd6, 8'hAA); idle(); bus_wr(3'd0, 8'h10);
    bus_rd(3'd0, d); check(d == 8'h00, "R5 late set after open cycle", d, 8'h00);
    bus_wr(3'd6, 8'h55); bus_wr(3'd6, 8'h12); bus_wr(3'd6, 8'hAA); bus_wr(3'd0, 8'h10);
    bus_rd(3'd0, d); check(d == 8'h00, "R6 wrong key between", d, 8'h00);
    bus_wr(3'd6, 8'hAA); bus_wr(3'd6, 8'h55); bus_wr(3'd0, 8'h10);
    bus_rd(3'd0, d); check(d == 8'h00, "R6 reversed keys", d, 8'h00);
    bus_wr(3'd6, 8'h55); bus_rd(3'd6, d); bus_wr(3'd6, 8'hAA); bus_wr(3'd0, 8'h10);
    bus_rd(3'd0, d); check(d == 8'h00, "R6 read between keys", d, 8'h00);
  endtask

  task automatic t_alarm();
    logic [DW-1:0] d;
    bus_wr(3'd0, 8'h01);
    bus_wr(3'd3, 8'h02);
    bus_rd(3'd4, d); check(d == 8'hC5, "R10 alarm ptr2 high is month", d, 8'hC5);
    bus_rd(3'd3, d); check(d == 8'h01, "R10 alarm ptr steps", d, 8'h01);
    bus_rd(3'd0, d); check(d == 8'h01, "R10 time ptr untouched", d, 8'h01);
    bus_wr(3'd5, 8'h5A);
    check(cap_al == 7'h04, "R10 alarm write ungated", cap_al, 7'h04);
    check(cap_tm == '0, "R10 alarm write no time strobe", cap_tm, 0);
    bus_wr(3'd4, 8'h5B); check(cap_al == 7'h08, "R10 alarm high strobes weekday", cap_al, 7'h08);
    bus_wr(3'd4, 8'h5C); check(cap_al == 7'h02, "R10 alarm ptr0 strobes minutes", cap_al, 7'h02);
    bus_rd(3'd3, d); check(d == 8'h00, "R3 alarm ptr floor", d, 8'h00);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_map_walk();
    t_locked();
    t_unlock_ok();
    t_unlock_bad();
    t_alarm();
    repeat (2) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule